// File: doc/BRIEF.md
# Single-Wire Bus Sleep and Wake Controller

This block is the digital mode and power-control logic of a single-wire bus transceiver. A host picks one of four operating codes on a two-bit select input. The codes are sleep, wake-up transmit, fast transmit and normal. The block passes that choice on to the analog transmitter. It also gates the transmit driver and the receive-data output that go back to the host. All inputs arrive as clean digital levels from analog circuits outside the block: the filtered high-voltage wake detect, the bus level, the transmit data, an under-voltage flag and an over-temperature flag. Each input passes through a two-flop synchronizer.

The block also drives a regulator-enable output that powers the host. In the sleep code, a wake level on the bus turns the regulator on. It stays on for a long hold window, measured in ticks of an external 500 kHz strobe. If the host never leaves the sleep code, the regulator is switched off when the window ends, even if the wake level is still on the bus. A new wake needs the wake level to drop and then return. With the default 200000 ticks the window is 400 ms, which is inside the allowed range of 300 ms to 1000 ms.

Top module: `swbus_pwr_ctrl`

## Requirements
- R1: The select input `mode_sel_i` is decoded as 2'b00 sleep, 2'b01 wake-up transmit, 2'b10 fast transmit and 2'b11 normal. `mode_o` presents the decoded code. Every input is seen at the outputs on the third rising clock edge after it changes (two synchronizer flops, then one output register).
- R2: While `rst_n` is low at a clock edge, the block returns to sleep: `reg_en_o`=0, `rxd_o`=1, `drv_en_o`=0, `drv_dom_o`=0 and `mode_o`=2'b00.
- R3: With the sleep code selected, a rising wake level on `wake_det_i` drives `reg_en_o` high.
- R4: After the wake level ends, with the sleep code still selected, `reg_en_o` stays high for HOLD_TICKS ticks and then goes low.
- R5: If the wake level stays high and the sleep code stays selected, `reg_en_o` goes low HOLD_TICKS ticks after the wake began. It does not go high again until `wake_det_i` goes low and then high.
- R6: Any non-sleep code keeps `reg_en_o` high for as long as it is selected. `reg_en_o` only falls while the sleep code is selected.
- R7: With the sleep code selected, `rxd_o` is 1 (inactive) unless the wake level is present. While the wake level is present, `rxd_o` is the inverse of `bus_dom_i`.
- R8: When the wake level ends during the sleep code, `rxd_o` keeps following the bus for RX_RET_TICKS ticks and then returns to 1.
- R9: In any non-sleep code, `rxd_o` is the inverse of `bus_dom_i` (0 means a dominant bus).
- R10: `txd_i`=0 requests the dominant state. In a non-sleep code, this sets `drv_en_o`=1 and `drv_dom_o`=1. In the sleep code, the driver stays off.
- R11: After `txd_i` returns to 1, `drv_dom_o` goes low and `drv_en_o` stays high for DRV_HOLD_TICKS ticks.
- R12: `uv_flag_i`=1 forces `drv_en_o`=0, `drv_dom_o`=0 and `rxd_o`=1. `ot_flag_i`=1 forces only the driver off and leaves `rxd_o` following the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 500 kHz, synchronous to clk |
| mode_sel_i | input | 2 | Operating code select, asynchronous |
| wake_det_i | input | 1 | Filtered high-voltage wake detect, asynchronous |
| bus_dom_i | input | 1 | Bus comparator, 1 = dominant, asynchronous |
| txd_i | input | 1 | Transmit data, 0 = dominant, asynchronous |
| uv_flag_i | input | 1 | Under-voltage flag, asynchronous |
| ot_flag_i | input | 1 | Over-temperature flag, asynchronous |
| reg_en_o | output | 1 | Regulator enable |
| rxd_o | output | 1 | Receive data, 1 = recessive or inactive |
| drv_en_o | output | 1 | Transmit driver enable |
| drv_dom_o | output | 1 | Driver commands dominant level |
| mode_o | output | 2 | Decoded code for level and waveshape selection |

## Verification
Level results appear on the third rising edge after an input change. The bench therefore waits several cycles after each stimulus and samples just after a clock edge. Timed results depend on the phase of the tick strobe, so they can land up to one tick early or late. Each timed result is checked twice: once a few ticks before its earliest due time, when the old value must still hold, and once after its latest due time, when the new value must be present. The bench uses small tick counts so that these windows are short.

// File: rtl/swbus_pkg.sv
// Package: shared codes for the single-wire bus sleep/wake controller.
// Assumes the select code is presented as a two-bit value.
package swbus_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'b00,
        MODE_WAKETX = 2'b01,
        MODE_FAST   = 2'b10,
        MODE_NORMAL = 2'b11
    } swb_mode_e;

    typedef enum logic [1:0] {
        PW_OFF  = 2'b00,
        PW_HOLD = 2'b01,
        PW_ON   = 2'b10
    } swb_pwr_e;

endpackage

// File: rtl/swb_sync.sv
// Module: two-flop synchronizer for a bundle of independent async levels.
// Assumes each bit is a slow level, so bits need no mutual coherence.
// There is no reset: the chain fills within two clocks of any input.
module swb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two-stage capture into the clk domain.
    always_ff @(posedge clk) begin
        meta_q <= async_i;
        stab_q <= meta_q;
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/swb_tick_timer.sv
// Module: down-counter measured in timebase ticks.
// A load sets the count to N. Each tick lowers it until it reaches zero.
// busy_o is high while the count is nonzero. A load takes priority over a tick.
module swb_tick_timer #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic load_i,
    output logic busy_o
);
    localparam int W = $clog2(N + 1);

    logic [W-1:0] cnt_q;

    // Count down one per tick after a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= W'(N);
        else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/swb_pwr_fsm.sv
// Module: regulator-enable state machine.
// A wake edge in the sleep code opens a hold window. The window restarts when
// the wake level ends. When it expires in the sleep code, the block returns to
// off, even with the wake level still present. Any non-sleep code keeps power on.
// Assumes synchronized inputs.
module swb_pwr_fsm
    import swbus_pkg::*;
#(
    parameter int HOLD_TICKS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sleep_code_i,
    input  logic wake_i,
    output logic reg_en_o
);
    swb_pwr_e state_q, state_d;
    logic     wake_q;
    logic     wake_rise, wake_fall;
    logic     hold_load, hold_busy;

    assign wake_rise = wake_i & ~wake_q;
    assign wake_fall = ~wake_i & wake_q;

    // Remember the previous wake level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_i;
    end

    // Next-state selection; a non-sleep code always wins.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PW_OFF:  if (!sleep_code_i)   state_d = PW_ON;
                     else if (wake_rise)  state_d = PW_HOLD;
            PW_ON:   if (sleep_code_i)    state_d = PW_HOLD;
            PW_HOLD: if (!sleep_code_i)   state_d = PW_ON;
                     else if (!hold_busy) state_d = PW_OFF;
            default:                      state_d = PW_OFF;
        endcase
    end

    // Restart the window on entry to hold and on the end of the wake level.
    assign hold_load = (state_d == PW_HOLD) &&
                       ((state_q != PW_HOLD) || wake_fall);

    swb_tick_timer #(.N(HOLD_TICKS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .load_i (hold_load),
        .busy_o (hold_busy)
    );

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PW_OFF;
            reg_en_o <= 1'b0;
        end else begin
            state_q  <= state_d;
            reg_en_o <= (state_d != PW_OFF);
        end
    end
endmodule

// File: rtl/swb_rx_gate.sv
// Module: receive-data gate.
// The path is open in any non-sleep code, while the wake level is present, and
// for a return window after the wake level ends in the sleep code.
// Under-voltage closes it. A closed path gives 1.
module swb_rx_gate #(
    parameter int RET_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sleep_code_i,
    input  logic wake_i,
    input  logic bus_dom_i,
    input  logic uv_i,
    output logic rxd_o
);
    logic wake_q;
    logic ret_load, ret_busy, path_open;

    // Previous wake level for the fall detect.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_i;
    end

    assign ret_load = wake_q & ~wake_i & sleep_code_i;

    swb_tick_timer #(.N(RET_TICKS)) u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .load_i (ret_load),
        .busy_o (ret_busy)
    );

    assign path_open = !uv_i && (!sleep_code_i || wake_i || ret_busy || ret_load);

    // Registered receive output, recessive when closed.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_o <= 1'b1;
        else        rxd_o <= path_open ? ~bus_dom_i : 1'b1;
    end
endmodule

// File: rtl/swb_tx_gate.sv
// Module: transmit driver gate.
// A low transmit input asks for dominant. The driver stays enabled for a hold
// window after each return to recessive. The sleep code, under-voltage and
// over-temperature each turn the driver off.
module swb_tx_gate #(
    parameter int DRV_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sleep_code_i,
    input  logic txd_i,
    input  logic uv_i,
    input  logic ot_i,
    output logic drv_en_o,
    output logic drv_dom_o
);
    logic txd_q;
    logic tx_dom, rel_load, rel_busy, allow, en_d;

    assign tx_dom = ~txd_i;

    // Previous transmit level for the release detect.
    always_ff @(posedge clk) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= txd_i;
    end

    assign rel_load = txd_i & ~txd_q;

    swb_tick_timer #(.N(DRV_TICKS)) u_rel (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .load_i (rel_load),
        .busy_o (rel_busy)
    );

    assign allow = !sleep_code_i && !uv_i && !ot_i;
    assign en_d  = allow && (tx_dom || rel_busy || rel_load);

    // Registered driver controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_en_o  <= 1'b0;
            drv_dom_o <= 1'b0;
        end else begin
            drv_en_o  <= en_d;
            drv_dom_o <= en_d && tx_dom;
        end
    end
endmodule

// File: rtl/swbus_pwr_ctrl.sv
// Module: top of the single-wire bus sleep/wake controller.
// Synchronizes the asynchronous inputs and decodes the select code. Feeds the
// power state machine, the receive gate and the transmit gate. Assumes tick_i
// is a one-cycle strobe in the clk domain.
module swbus_pwr_ctrl
    import swbus_pkg::*;
#(
    parameter int HOLD_TICKS   = 200000,
    parameter int RX_RET_TICKS = 32,
    parameter int DRV_TICKS    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [1:0] mode_sel_i,
    input  logic       wake_det_i,
    input  logic       bus_dom_i,
    input  logic       txd_i,
    input  logic       uv_flag_i,
    input  logic       ot_flag_i,
    output logic       reg_en_o,
    output logic       rxd_o,
    output logic       drv_en_o,
    output logic       drv_dom_o,
    output logic [1:0] mode_o
);
    localparam int NSYNC = 7;

    logic [NSYNC-1:0] raw_in, syn;
    swb_mode_e        mode_s;
    logic             wake_s, bus_s, txd_s, uv_s, ot_s, sleep_code;

    assign raw_in = {mode_sel_i, wake_det_i, bus_dom_i, txd_i, uv_flag_i, ot_flag_i};

    swb_sync #(.W(NSYNC)) u_sync (
        .clk     (clk),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    assign mode_s     = swb_mode_e'(syn[6:5]);
    assign wake_s     = syn[4];
    assign bus_s      = syn[3];
    assign txd_s      = syn[2];
    assign uv_s       = syn[1];
    assign ot_s       = syn[0];
    assign sleep_code = (mode_s == MODE_SLEEP);

    swb_pwr_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .sleep_code_i (sleep_code),
        .wake_i       (wake_s),
        .reg_en_o     (reg_en_o)
    );

    swb_rx_gate #(.RET_TICKS(RX_RET_TICKS)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .sleep_code_i (sleep_code),
        .wake_i       (wake_s),
        .bus_dom_i    (bus_s),
        .uv_i         (uv_s),
        .rxd_o        (rxd_o)
    );

    swb_tx_gate #(.DRV_TICKS(DRV_TICKS)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .sleep_code_i (sleep_code),
        .txd_i        (txd_s),
        .uv_i         (uv_s),
        .ot_i         (ot_s),
        .drv_en_o     (drv_en_o),
        .drv_dom_o    (drv_dom_o)
    );

    // Registered view of the decoded code for the analog side.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_o <= MODE_SLEEP;
        else        mode_o <= mode_s;
    end
endmodule

// File: rtl/swbus_pwr_ctrl_chk.sv
// Module: property checker for swbus_pwr_ctrl, attached by bind.
// Observes top-level ports only. A flag held for four edges must be
// reflected at the outputs.
module swbus_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uv_flag_i,
    input logic       ot_flag_i,
    input logic       reg_en_o,
    input logic       rxd_o,
    input logic       drv_en_o,
    input logic       drv_dom_o,
    input logic [1:0] mode_o
);
    // R2
    reset_sleep_chk: assert property (@(posedge clk) !rst_n |=> (!reg_en_o && rxd_o && !drv_en_o));

    // R10
    dom_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n) drv_dom_o |-> drv_en_o);

    // R10
    sleep_drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n) (mode_o == 2'b00) |-> !drv_en_o);

    // R6
    fall_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(reg_en_o) |-> (mode_o == 2'b00));

    // R12
    uv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag_i && $past(uv_flag_i) && $past(uv_flag_i, 2) && $past(uv_flag_i, 3))
        |-> (!drv_en_o && rxd_o));

    // R12
    ot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag_i && $past(ot_flag_i) && $past(ot_flag_i, 2) && $past(ot_flag_i, 3))
        |-> !drv_en_o);
endmodule

bind swbus_pwr_ctrl swbus_pwr_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_flag_i (uv_flag_i),
    .ot_flag_i (ot_flag_i),
    .reg_en_o  (reg_en_o),
    .rxd_o     (rxd_o),
    .drv_en_o  (drv_en_o),
    .drv_dom_o (drv_dom_o),
    .mode_o    (mode_o)
);

// File: tb/sim_swbus_pwr_ctrl.sv
// Bench: table walk over static codes and flags, then directed timing tests.
// A tick every 4 clocks; hold 40, return 6, driver 4 ticks.
module sim_swbus_pwr_ctrl;
    localparam int HOLD = 40;
    localparam int RET  = 6;
    localparam int DRV  = 4;
    localparam int TP   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       wake = 1'b0, bus_dom = 1'b0, txd = 1'b1, uv = 1'b0, ot = 1'b0;
    logic       reg_en, rxd, drv_en, drv_dom;
    logic [1:0] mode_out;
    int         tick_cnt = 0;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    // Timebase strobe, one cycle in TP.
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TP - 1) ? 0 : tick_cnt + 1;
        tick     <= (tick_cnt == TP - 1);
    end

    swbus_pwr_ctrl #(.HOLD_TICKS(HOLD), .RX_RET_TICKS(RET), .DRV_TICKS(DRV)) u0 (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .mode_sel_i (mode_sel),
        .wake_det_i (wake), .bus_dom_i (bus_dom), .txd_i (txd),
        .uv_flag_i (uv), .ot_flag_i (ot), .reg_en_o (reg_en), .rxd_o (rxd),
        .drv_en_o (drv_en), .drv_dom_o (drv_dom), .mode_o (mode_out)
    );

    // Row: mode[8:7] txd[6] bus[5] uv[4] ot[3] | exp en[2] dom[1] rxd[0]
    localparam logic [8:0] VEC [0:9] = '{
        9'b11_0_1_0_0_110, 9'b11_1_0_0_0_001, 9'b10_0_0_0_0_111,
        9'b01_0_1_0_0_110, 9'b11_0_1_0_1_000, 9'b11_0_1_1_0_001,
        9'b10_1_1_0_0_000, 9'b00_0_1_0_0_001, 9'b00_1_0_0_0_001,
        9'b01_1_0_1_1_001
    };

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mode_sel = 2'b00; wake = 0; bus_dom = 0; txd = 1; uv = 0; ot = 0;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R2 reset state
        chk({reg_en, rxd}, 2'b01, "R2 reg_en/rxd after reset");
        chk({drv_en, drv_dom}, 2'b00, "R2 driver after reset");
        chk(mode_out, 2'b00, "R2 mode after reset");

        // Table walk: R1 R9 R10 R12
        for (int i = 0; i < 10; i++) begin
            mode_sel = VEC[i][8:7]; txd = VEC[i][6]; bus_dom = VEC[i][5];
            uv = VEC[i][4]; ot = VEC[i][3];
            cyc(40);
            chk(mode_out, VEC[i][8:7], $sformatf("R1 row %0d mode", i));
            chk({drv_en, drv_dom}, VEC[i][2:1], $sformatf("R10/R12 row %0d driver", i));
            chk({1'b0, rxd}, {1'b0, VEC[i][0]}, $sformatf("R9/R12 row %0d rxd", i));
        end

        // R3 R7 R8 R4: wake in sleep, then release
        do_reset();
        bus_dom = 1; cyc(6);
        chk({1'b0, rxd}, 2'b01, "R7 sleep rxd inactive");
        wake = 1; cyc(4);
        chk({1'b0, reg_en}, 2'b01, "R3 reg_en on wake");
        chk({1'b0, rxd}, 2'b00, "R7 rxd follows dominant bus");
        bus_dom = 0; cyc(4);
        chk({1'b0, rxd}, 2'b01, "R7 rxd follows recessive bus");
        bus_dom = 1; wake = 0; cyc(4);
        chk({1'b0, rxd}, 2'b00, "R8 rxd still following");
        cyc(30);
        chk({1'b0, rxd}, 2'b01, "R8 rxd back to inactive");
        cyc(106);
        chk({1'b0, reg_en}, 2'b01, "R4 reg_en held in window");
        cyc(35);
        chk({1'b0, reg_en}, 2'b00, "R4 reg_en low after window");

        // R5: wake stuck high
        wake = 1; cyc(4);
        chk({1'b0, reg_en}, 2'b01, "R5 reg_en on second wake");
        cyc(136);
        chk({1'b0, reg_en}, 2'b01, "R5 reg_en inside window");
        cyc(35);
        chk({1'b0, reg_en}, 2'b00, "R5 forced off with wake present");
        cyc(40);
        chk({1'b0, reg_en}, 2'b00, "R5 no re-wake without new edge");
        wake = 0; cyc(8); wake = 1; cyc(4);
        chk({1'b0, reg_en}, 2'b01, "R5 re-wake after new edge");

        // R6: host takes over
        mode_sel = 2'b11; cyc(300);
        chk({1'b0, reg_en}, 2'b01, "R6 stays on in normal code");
        mode_sel = 2'b00; wake = 0; cyc(140);
        chk({1'b0, reg_en}, 2'b01, "R6 hold after back to sleep code");
        cyc(35);
        chk({1'b0, reg_en}, 2'b00, "R6 off after hold");

        // R10 R11: driver hold
        do_reset();
        mode_sel = 2'b11; txd = 0; cyc(6);
        chk({drv_en, drv_dom}, 2'b11, "R10 dominant drive");
        txd = 1; cyc(4);
        chk({drv_en, drv_dom}, 2'b10, "R11 enable held, passive");
        cyc(4);
        chk({drv_en, drv_dom}, 2'b10, "R11 enable still held");
        cyc(22);
        chk({drv_en, drv_dom}, 2'b00, "R11 enable released");

        // R12: under-voltage closes wake receive path but not wake power-up
        do_reset();
        uv = 1; bus_dom = 1; wake = 1; cyc(6);
        chk({reg_en, rxd}, 2'b11, "R12 uv rxd inactive, reg_en on");

        // R2: reset during activity
        rst_n = 0; cyc(2);
        chk({reg_en, drv_en}, 2'b00, "R2 reset mid-run");
        rst_n = 1; cyc(2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule